// File: doc/BRIEF.md
# SPI Bus Timing Monitor

This block watches the select, clock and four-bit data lines of an SPI bus. It samples them with a much faster logic clock and checks each sample against a set of minimum-duration rules. Every rule is counted in whole logic-clock cycles. The rules cover:

- select setup against a quiet clock,
- clock quiet time after selection,
- deselect hold,
- minimum deselect time before reselection,
- minimum SCK high and low times,
- data hold around rising SCK edges.

The monitor never drives the bus. It reports the first broken rule on a sticky error flag and a one-hot code, and both hold until reset.

The inputs are sampled on every rising edge of `clk`. Each rising edge is one "sample" t. The first sample after reset is t0. The history before t0 is taken as an idle bus: select high, SCK low, data zero. A rule broken by sample t shows on `err_flag`/`err_code` immediately after the edge that took sample t. The monitor has no data path, so no valid/ready handshake is involved. Its output pins are plain status.

Top module: `spi_tmon`

## Requirements
- R1: While `rst_n` is low, and right after it, `err_flag` is 0 and `err_code` is 0.
- R2: Select low (`cs_n`=0) on sample t0 sets code bit 0 (8'h01).
- R3: A select fall (`cs_n` 1 at t-1, 0 at t) sets code bit 1 (8'h02) unless SCK is low at t, t-1 and t-2.
- R4: SCK high in the first three samples of a selection (the fall sample and the two after it) sets code bit 2 (8'h04).
- R5: A select rise (`cs_n` 0 at t-1, 1 at t) sets code bit 3 (8'h08) unless SCK is low at t, t-1 and t-2.
- R6: After a select rise at tr, `cs_n` must stay high through tr+4. A fall earlier than tr+5 sets code bit 4 (8'h10). A fall at tr+5 is legal.
- R7: After an SCK rise, SCK must stay high for at least five samples. Falling sooner sets bit 5 (8'h20). After an SCK fall, SCK must stay low for at least five samples. Rising sooner sets bit 6 (8'h40).
- R8: While SCK is high, `sdi` must not change on the rise sample or on the two samples that follow it. A change there sets bit 7 (8'h80). A change on the third sample after the rise is legal.
- R9: `err_flag` is sticky until reset, and `err_code` keeps the first violation.
- R10: When several rules break on the same sample, only the lowest-numbered code bit is recorded.
- R11: On sample t0, only the check of R2 is active. All other rules are suppressed.
- R12: A violation taken on sample t is visible at the outputs right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Bus select, active low |
| sck | input | 1 | Bus serial clock |
| sdi | input | DW (4) | Bus data lines |
| err_flag | output | 1 | Sticky: some rule has been broken |
| err_code | output | 8 | One-hot index of the first broken rule |

## Verification
Every internal fault shows up at the ports, and each kind shows up in its own way.

A run counter that restarts or saturates wrongly moves a rule boundary by one sample. The flag then rises one edge early on a legal waveform, or stays low on the sample that should trip it. The bench places legal waveforms exactly at each limit to catch this.

A wrong priority pick or a latch that is not sticky shows as a different one-hot code. That code appears either on the violating edge or on a later edge, when a second rule breaks.

A wrong suppression of the first sample either trips on t0 or misses a select that is held low through reset.

// File: rtl/spi_tmon_pkg.sv
package spi_tmon_pkg;

  localparam int unsigned RULE_COUNT = 8;

  // Bit position of each rule in the violation vector; lower index wins.
  typedef enum logic [2:0] {
    RULE_SEL_AT_RESET = 3'd0,
    RULE_SEL_SETUP    = 3'd1,
    RULE_SEL_QUIET    = 3'd2,
    RULE_DESEL_HOLD   = 3'd3,
    RULE_RESEL_GAP    = 3'd4,
    RULE_SCK_HIGH     = 3'd5,
    RULE_SCK_LOW      = 3'd6,
    RULE_DATA_HOLD    = 3'd7
  } rule_e;

  typedef logic [RULE_COUNT-1:0] rule_vec_t;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_tmon_run.sv
// Level tracker: last sampled level plus saturating length of its run.
module spi_tmon_run #(
  parameter int unsigned CW       = 3,
  parameter int unsigned SAT      = 5,
  parameter bit          IDLE_LVL = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl_i,
  output logic          lvl_q,
  output logic [CW-1:0] run_q
);

  localparam logic [CW-1:0] RUN_MAX = CW'(SAT);

  // Reset pretends the line has idled long enough to satisfy every limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= IDLE_LVL;
      run_q <= RUN_MAX;
    end else begin
      lvl_q <= lvl_i;
      if (lvl_i != lvl_q)
        run_q <= CW'(1);
      else if (run_q != RUN_MAX)
        run_q <= run_q + CW'(1);
    end
  end

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_i != lvl_q) |=> (run_q == CW'(1)));  // R7

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != '0) && (run_q <= RUN_MAX));  // R7

endmodule

// File: rtl/spi_tmon_rules.sv
// Combinational rule evaluation for the current sample against history.
module spi_tmon_rules
  import spi_tmon_pkg::*;
#(
  parameter int unsigned DW         = 4,
  parameter int unsigned CW         = 3,
  parameter int unsigned SEL_IDLE   = 2,
  parameter int unsigned SEL_QUIET  = 3,
  parameter int unsigned DESEL_IDLE = 2,
  parameter int unsigned RESEL_GAP  = 4,
  parameter int unsigned EDGE_HOLD  = 4,
  parameter int unsigned DATA_HOLD  = 2
) (
  input  logic          first_i,
  input  logic          cs_n_i,
  input  logic          cs_n_q,
  input  logic [CW-1:0] cs_run_i,
  input  logic          sck_i,
  input  logic          sck_q,
  input  logic [CW-1:0] sck_run_i,
  input  logic [DW-1:0] sdi_i,
  input  logic [DW-1:0] sdi_q,
  output rule_vec_t     viol_o
);

  localparam logic [CW-1:0] L_SEL_IDLE   = CW'(SEL_IDLE);
  localparam logic [CW-1:0] L_SEL_QUIET  = CW'(SEL_QUIET);
  localparam logic [CW-1:0] L_DESEL_IDLE = CW'(DESEL_IDLE);
  localparam logic [CW-1:0] L_RESEL_GAP  = CW'(RESEL_GAP);
  localparam logic [CW-1:0] L_EDGE_HOLD  = CW'(EDGE_HOLD);
  localparam logic [CW-1:0] L_DATA_HOLD  = CW'(DATA_HOLD);

  logic          sel_fall, desel_rise, sck_rise, sck_fall;
  logic          sel_quiet_ok, desel_quiet_ok;
  logic [CW-1:0] sel_age, sck_age;

  always_comb begin
    sel_fall   = cs_n_q & ~cs_n_i;
    desel_rise = ~cs_n_q & cs_n_i;
    sck_rise   = ~sck_q & sck_i;
    sck_fall   = sck_q & ~sck_i;

    // Low run ending at t-1 covers t-1 and earlier; t itself must be low too.
    sel_quiet_ok   = ~sck_i & ~sck_q & (sck_run_i >= L_SEL_IDLE);
    desel_quiet_ok = ~sck_i & ~sck_q & (sck_run_i >= L_DESEL_IDLE);

    // Samples elapsed since the select fall (0 on the fall sample itself).
    sel_age = (cs_n_q == cs_n_i) ? cs_run_i : '0;
    // Samples elapsed since the SCK rise (0 on the rise sample itself).
    sck_age = sck_q ? sck_run_i : '0;

    viol_o = '0;
    viol_o[RULE_SEL_AT_RESET] = first_i & ~cs_n_i;
    if (!first_i) begin
      viol_o[RULE_SEL_SETUP]  = sel_fall & ~sel_quiet_ok;
      viol_o[RULE_SEL_QUIET]  = ~cs_n_i & sck_i & (sel_age < L_SEL_QUIET);
      viol_o[RULE_DESEL_HOLD] = desel_rise & ~desel_quiet_ok;
      viol_o[RULE_RESEL_GAP]  = sel_fall & (cs_run_i <= L_RESEL_GAP);
      viol_o[RULE_SCK_HIGH]   = sck_fall & (sck_run_i <= L_EDGE_HOLD);
      viol_o[RULE_SCK_LOW]    = sck_rise & (sck_run_i <= L_EDGE_HOLD);
      viol_o[RULE_DATA_HOLD]  = sck_i & (sdi_i != sdi_q) & (sck_age <= L_DATA_HOLD);
    end
  end

endmodule

// File: rtl/spi_tmon_latch.sv
// First-violation capture: lowest set bit wins, then frozen until reset.
module spi_tmon_latch
  import spi_tmon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rule_vec_t viol_i,
  output logic      err_o,
  output rule_vec_t code_o
);

  rule_vec_t pick;
  logic      hit;

  always_comb begin
    pick = '0;
    hit  = 1'b0;
    for (int i = 0; i < int'(RULE_COUNT); i++) begin
      if (viol_i[i] && !hit) begin
        pick[i] = 1'b1;
        hit     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_o  <= 1'b0;
      code_o <= '0;
    end else if (!err_o && hit) begin
      err_o  <= 1'b1;
      code_o <= pick;
    end
  end

  AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $onehot(code_o));  // R10

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o && $stable(code_o)));  // R9

  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ($past(viol_i) != '0));  // R12

endmodule

// File: rtl/spi_tmon.sv
module spi_tmon
  import spi_tmon_pkg::*;
#(
  parameter int unsigned DW         = 4,
  parameter int unsigned SEL_IDLE   = 2,
  parameter int unsigned SEL_QUIET  = 3,
  parameter int unsigned DESEL_IDLE = 2,
  parameter int unsigned RESEL_GAP  = 4,
  parameter int unsigned EDGE_HOLD  = 4,
  parameter int unsigned DATA_HOLD  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sck,
  input  logic [DW-1:0]         sdi,
  output logic                  err_flag,
  output logic [RULE_COUNT-1:0] err_code
);

  localparam int unsigned LIM = umax(umax(umax(SEL_IDLE, SEL_QUIET), umax(DESEL_IDLE, RESEL_GAP)),
                                     umax(EDGE_HOLD, DATA_HOLD));
  localparam int unsigned SAT = LIM + 1;
  localparam int unsigned CW  = $clog2(SAT + 1);

  logic          first_q;
  logic          cs_n_q, sck_q;
  logic [CW-1:0] cs_run, sck_run;
  logic [DW-1:0] sdi_q;
  rule_vec_t     viol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      sdi_q   <= '0;
    end else begin
      first_q <= 1'b0;
      sdi_q   <= sdi;
    end
  end

  spi_tmon_run #(.CW(CW), .SAT(SAT), .IDLE_LVL(1'b1)) u_cs_run (
    .clk(clk), .rst_n(rst_n), .lvl_i(cs_n), .lvl_q(cs_n_q), .run_q(cs_run)
  );

  spi_tmon_run #(.CW(CW), .SAT(SAT), .IDLE_LVL(1'b0)) u_sck_run (
    .clk(clk), .rst_n(rst_n), .lvl_i(sck), .lvl_q(sck_q), .run_q(sck_run)
  );

  spi_tmon_rules #(
    .DW(DW), .CW(CW), .SEL_IDLE(SEL_IDLE), .SEL_QUIET(SEL_QUIET), .DESEL_IDLE(DESEL_IDLE),
    .RESEL_GAP(RESEL_GAP), .EDGE_HOLD(EDGE_HOLD), .DATA_HOLD(DATA_HOLD)
  ) u_rules (
    .first_i(first_q), .cs_n_i(cs_n), .cs_n_q(cs_n_q), .cs_run_i(cs_run),
    .sck_i(sck), .sck_q(sck_q), .sck_run_i(sck_run),
    .sdi_i(sdi), .sdi_q(sdi_q), .viol_o(viol)
  );

  spi_tmon_latch u_latch (
    .clk(clk), .rst_n(rst_n), .viol_i(viol), .err_o(err_flag), .code_o(err_code)
  );

  AST_SEL_AT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q && !cs_n && !err_flag) |=> (err_code == RULE_COUNT'(1)));  // R2

  AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q && cs_n && !err_flag) |=> !err_flag);  // R11

endmodule

// File: tb/spi_tmon_tb_top.sv
module spi_tmon_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic [3:0] sdi = 4'd0;
  logic       err_flag;
  logic [7:0] err_code;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  spi_tmon dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .err_flag(err_flag), .err_code(err_code)
  );

  // Behavioural reference: full sample history, rules read straight off it.
  int         h_cs[$];
  int         h_sck[$];
  int         h_d[$];
  bit         m_err;
  logic [7:0] m_code;

  function automatic int pre(input int w);
    return (w == 0) ? 1 : 0;
  endfunction

  function automatic int at(input int w, input int i);
    if (i < 0) return pre(w);
    case (w)
      0:       return h_cs[i];
      1:       return h_sck[i];
      default: return h_d[i];
    endcase
  endfunction

  // Length of the run of value lvl ending at sample last (idle prehistory is endless).
  function automatic int run_of(input int w, input int lvl, input int last);
    int cnt = 0;
    for (int i = last; i >= -1; i--) begin
      if (i < 0) return (lvl == pre(w)) ? 99 : cnt;
      if (at(w, i) != lvl) return cnt;
      cnt++;
    end
    return cnt;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cs.delete(); h_sck.delete(); h_d.delete();
      m_err  = 1'b0;
      m_code = 8'h00;
    end else begin
      logic [7:0] mv;
      int t, c, pc, k, pk, k2;
      h_cs.push_back(int'(cs_n));
      h_sck.push_back(int'(sck));
      h_d.push_back(int'(sdi));
      t  = h_cs.size() - 1;
      mv = 8'h00;
      c = at(0, t); pc = at(0, t-1);
      k = at(1, t); pk = at(1, t-1); k2 = at(1, t-2);
      if (t == 0) begin
        mv[0] = (c == 0);
      end else begin
        mv[1] = (pc == 1 && c == 0) && !(k == 0 && pk == 0 && k2 == 0);
        mv[2] = (c == 0 && k == 1 && run_of(0, 0, t) <= 3);
        mv[3] = (pc == 0 && c == 1) && !(k == 0 && pk == 0 && k2 == 0);
        mv[4] = (pc == 1 && c == 0 && run_of(0, 1, t-1) < 5);
        mv[5] = (pk == 1 && k == 0 && run_of(1, 1, t-1) < 5);
        mv[6] = (pk == 0 && k == 1 && run_of(1, 0, t-1) < 5);
        mv[7] = (k == 1 && at(2, t) != at(2, t-1) && run_of(1, 1, t) <= 3);
      end
      if (!m_err && mv != 8'h00) begin
        m_err = 1'b1;
        for (int b = 7; b >= 0; b--) if (mv[b]) m_code = 8'h01 << b;
      end
    end
  end

  // Per-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (err_flag !== m_err || err_code !== m_code) begin
        n_bad++;
        $display("FAIL %s (cycle compare): err=%0b code=%02h expected err=%0b code=%02h",
                 tag, err_flag, err_code, m_err, m_code);
      end
    end
  end

  task automatic check(input string r, input bit e_err, input logic [7:0] e_code);
    n_chk++;
    if (err_flag !== e_err || err_code !== e_code) begin
      n_bad++;
      $display("FAIL %s: err=%0b code=%02h expected err=%0b code=%02h",
               r, err_flag, err_code, e_err, e_code);
    end
  endtask

  task automatic cyc(input logic c, input logic k, input logic [3:0] d);
    cs_n = c; sck = k; sdi = d;
    @(posedge clk); #1;
  endtask

  task automatic cycn(input int n, input logic c, input logic k, input logic [3:0] d);
    for (int i = 0; i < n; i++) cyc(c, k, d);
  endtask

  task automatic do_reset(input logic cs_during);
    @(posedge clk); #1;
    rst_n = 1'b0; cs_n = cs_during; sck = 1'b0; sdi = 4'd0;
    @(posedge clk); #1;
    check("R1", 1'b0, 8'h00);
    @(posedge clk); #1;
    rst_n = 1'b1;
    check("R1", 1'b0, 8'h00);
  endtask

  task automatic select_pre();
    cycn(3, 1'b1, 1'b0, 4'd0);
    cycn(3, 1'b0, 1'b0, 4'd0);
  endtask

  initial begin
    // R1 reset state; legal frame with every limit met exactly
    tag = "R7"; do_reset(1'b1);
    select_pre();
    for (int b = 0; b < 2; b++) begin
      cycn(5, 1'b0, 1'b1, 4'(b));
      cycn(5, 1'b0, 1'b0, 4'(b + 1));
    end
    check("R7", 1'b0, 8'h00);
    tag = "R6";
    cycn(5, 1'b1, 1'b0, 4'd2);
    cyc(1'b0, 1'b0, 4'd2);                  // reselect exactly at tr+5
    check("R6", 1'b0, 8'h00);

    // R2: select held low through reset release
    tag = "R2"; do_reset(1'b0);
    cyc(1'b0, 1'b0, 4'd0);
    check("R2", 1'b1, 8'h01);

    // R3: select falls with SCK low for only one prior sample
    tag = "R3"; do_reset(1'b1);
    cycn(6, 1'b1, 1'b1, 4'd0);
    cyc(1'b1, 1'b0, 4'd0);
    cyc(1'b0, 1'b0, 4'd0);
    check("R3", 1'b1, 8'h02);

    // R4 and R12: SCK rises on the third sample of a selection
    tag = "R4"; do_reset(1'b1);
    cycn(3, 1'b1, 1'b0, 4'd0);
    cycn(2, 1'b0, 1'b0, 4'd0);
    check("R12", 1'b0, 8'h00);
    cyc(1'b0, 1'b1, 4'd0);
    check("R4", 1'b1, 8'h04);

    // R5: deselect with SCK low only two samples
    tag = "R5"; do_reset(1'b1);
    select_pre();
    cycn(5, 1'b0, 1'b1, 4'd0);
    cyc(1'b0, 1'b0, 4'd0);
    cyc(1'b1, 1'b0, 4'd0);
    check("R5", 1'b1, 8'h08);

    // R6: reselect two samples after deselect
    tag = "R6"; do_reset(1'b1);
    select_pre();
    cycn(2, 1'b1, 1'b0, 4'd0);
    cyc(1'b0, 1'b0, 4'd0);
    check("R6", 1'b1, 8'h10);

    // R7 high time too short, then R9 sticky under further violations
    tag = "R7"; do_reset(1'b1);
    select_pre();
    cycn(4, 1'b0, 1'b1, 4'd0);
    cyc(1'b0, 1'b0, 4'd0);
    check("R7", 1'b1, 8'h20);
    tag = "R9";
    cyc(1'b0, 1'b1, 4'd7);
    cyc(1'b1, 1'b1, 4'd3);
    check("R9", 1'b1, 8'h20);

    // R7 low time too short
    tag = "R7"; do_reset(1'b1);
    select_pre();
    cycn(5, 1'b0, 1'b1, 4'd0);
    cycn(3, 1'b0, 1'b0, 4'd0);
    cyc(1'b0, 1'b1, 4'd0);
    check("R7", 1'b1, 8'h40);

    // R8: data changes one sample after the rise
    tag = "R8"; do_reset(1'b1);
    select_pre();
    cyc(1'b0, 1'b1, 4'd0);
    cyc(1'b0, 1'b1, 4'd1);
    check("R8", 1'b1, 8'h80);

    // R8 boundary: change on the third sample after the rise is legal
    do_reset(1'b1);
    select_pre();
    cycn(3, 1'b0, 1'b1, 4'd0);
    cycn(2, 1'b0, 1'b1, 4'd5);
    check("R8", 1'b0, 8'h00);

    // R10: select fall, SCK rise and data change together -> lowest bit
    tag = "R10"; do_reset(1'b1);
    cycn(3, 1'b1, 1'b0, 4'd0);
    cyc(1'b0, 1'b1, 4'd9);
    check("R10", 1'b1, 8'h02);

    // R11: first sample with SCK high and new data is not checked
    tag = "R11"; do_reset(1'b1);
    cyc(1'b1, 1'b1, 4'd5);
    check("R11", 1'b0, 8'h00);
    cycn(5, 1'b1, 1'b1, 4'd5);
    cyc(1'b1, 1'b0, 4'd5);
    check("R11", 1'b0, 8'h00);

    // R1 again: reset clears a sticky error
    tag = "R1"; do_reset(1'b1);
    check("R1", 1'b0, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule